// File: doc/BRIEF.md
# Multichannel DAC power-down controller

This block keeps the operating state of a four-channel digital-to-analog converter and turns it into the digital controls for each channel's output stage. Each channel stores a 2-bit power-down mode, a reference-select bit and a DAC input code. From the mode it derives three outputs. The first is an amplifier enable. The second is a one-hot select for one of three pull-down loads. The third is an output-valid flag that stays low during the settling delay after the channel wakes. One shared output enables the internal voltage reference.

Commands arrive as strobes that are already decoded. A channel write carries a channel index, new power-down bits and a reference select. A broadcast wake-up clears every channel's power-down mode. A broadcast reset reloads the modes, reference selects and DAC codes of all channels from saved values on the shadow input ports. The stored codes change only through the broadcast reset, so powering a channel down or up never alters its code. The wake-up delay length is a whole number of clock cycles, ceil(CLK_HZ * WAKE_NS / 1e9), where CLK_HZ is the clock frequency in hertz and WAKE_NS is the required delay in nanoseconds.

Top module: `dacpd_ctrl`

## Requirements
- R1: A channel write changes only the mode and reference select of the channel named by `wr_ch`. All other channels keep their state.
- R2: Mode encoding per channel. 00 means normal: `amp_en` is 1 and all three load bits are 0. 01 means 1 kΩ load (`load_sel` bit 0). 10 means 100 kΩ load (bit 1). 11 means 500 kΩ load (bit 2). In all three nonzero modes `amp_en` is 0.
- R3: In any nonzero mode exactly one of the channel's three load-select bits is high. In normal mode none is high.
- R4: `vref_int_en` is 0 only when every channel's reference select is 0 (external supply). If any channel selects internal (1), it is 1, whatever that channel's mode.
- R5: A write with power-down bits 00 returns the addressed channel to normal mode on the next cycle.
- R6: `gc_wake_stb` sets every channel to mode 00 and leaves reference selects and codes unchanged.
- R7: `gc_reset_stb` loads channel i's mode from `shadow_pd[2i+1:2i]`, its reference select from `shadow_vref[i]` and its code from `shadow_code[12i+11:12i]` for the default width. The new outputs follow the loaded mode.
- R8: `dac_code` changes only on a cycle after `gc_reset_stb`. Mode changes never alter it.
- R9: When a command takes a powered-down channel to normal, that channel's `out_valid` is low for exactly WAKE_CYC cycles after the command edge and rises on the next one. `out_valid` is low while the channel is powered down.
- R10: A further command that leaves the channel normal while its delay is running restarts the full WAKE_CYC delay from that command.
- R11: Priority per channel: broadcast reset first, then a write to that channel, then broadcast wake-up. A wake-up and a write in the same cycle still wake every channel the write does not address.
- R12: After reset every channel is normal with internal reference selected, code 0 and `out_valid` 1, and `vref_int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_stb | input | 1 | Channel write strobe |
| wr_ch | input | 2 | Channel index of the write |
| wr_pd | input | 2 | Power-down bits of the write |
| wr_vref | input | 1 | Reference select of the write (1 internal, 0 external) |
| gc_wake_stb | input | 1 | Broadcast wake-up strobe |
| gc_reset_stb | input | 1 | Broadcast reset (reload from shadow) strobe |
| shadow_pd | input | 8 | Saved power-down bits, 2 per channel |
| shadow_vref | input | 4 | Saved reference selects, 1 per channel |
| shadow_code | input | 48 | Saved DAC codes, 12 per channel |
| amp_en | output | 4 | Output amplifier enable per channel |
| load_sel | output | 12 | One-hot load select, 3 per channel |
| out_valid | output | 4 | Analog output valid per channel |
| vref_int_en | output | 1 | Internal reference enable |
| dac_code | output | 48 | Stored DAC code, 12 per channel |

## Verification
The hardest case to reach from the ports is a restart of the wake delay. The bench has to put a channel into power-down, issue a wake command, and then send a second wake event partway through the count. It must then show that `out_valid` stays low past the point where the first count would have ended. The bench does this with a short delay parameter and a fixed gap between the two writes. It counts cycles from the second command edge and samples `out_valid` at exactly WAKE_CYC and WAKE_CYC+1. Same-cycle collisions of wake-up, write and reset are driven in one cycle to exercise the priority order.

// File: rtl/dacpd_pkg.sv
package dacpd_pkg;

  typedef enum logic [1:0] {
    PD_ON   = 2'b00,
    PD_1K   = 2'b01,
    PD_100K = 2'b10,
    PD_500K = 2'b11
  } pd_mode_t;

  localparam int LOAD_W = 3;

endpackage

// File: rtl/dacpd_load_dec.sv
module dacpd_load_dec
  import dacpd_pkg::*;
(
  input  pd_mode_t              mode,
  output logic                  amp_en,
  output logic [LOAD_W-1:0]     load_sel
);

  assign amp_en = (mode == PD_ON);

  for (genvar k = 0; k < LOAD_W; k++) begin : g_load
    assign load_sel[k] = (mode == pd_mode_t'(2'(k + 1)));
  end

endmodule

// File: rtl/dacpd_wake_timer.sv
module dacpd_wake_timer #(
  parameter int WAKE_CYC = 1125,
  parameter int CNT_W    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAKE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start | abort | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = LOAD_VAL;
    end else if (abort) begin
      cnt_d = '0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dacpd_chan.sv
module dacpd_chan
  import dacpd_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int WAKE_CYC = 1125,
  parameter int CNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [1:0]        wr_pd,
  input  logic              wr_vref,
  input  logic              wake,
  input  logic              greset,
  input  logic [1:0]        sh_pd,
  input  logic              sh_vref,
  input  logic [CODE_W-1:0] sh_code,
  output logic              amp_en,
  output logic [LOAD_W-1:0] load_sel,
  output logic              out_valid,
  output logic              vref_q,
  output logic [CODE_W-1:0] code_q
);

  pd_mode_t          pd_q;
  pd_mode_t          pd_d;
  logic              vref_d;
  logic [CODE_W-1:0] code_d;
  logic              st_en;
  logic              code_en;
  logic              wake_evt;
  logic              abort;
  logic              busy;

  // next-state: reset reload, then addressed write, then broadcast wake
  always_comb begin
    pd_d    = pd_q;
    vref_d  = vref_q;
    code_d  = code_q;
    st_en   = 1'b0;
    code_en = 1'b0;
    if (greset) begin
      pd_d    = pd_mode_t'(sh_pd);
      vref_d  = sh_vref;
      code_d  = sh_code;
      st_en   = 1'b1;
      code_en = 1'b1;
    end else if (wr_sel) begin
      pd_d   = pd_mode_t'(wr_pd);
      vref_d = wr_vref;
      st_en  = 1'b1;
    end else if (wake) begin
      pd_d  = PD_ON;
      st_en = 1'b1;
    end
  end

  assign wake_evt = st_en && (pd_d == PD_ON) && ((pd_q != PD_ON) || busy);
  assign abort    = st_en && (pd_d != PD_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= PD_ON;
      vref_q <= 1'b1;
    end else if (st_en) begin
      pd_q   <= pd_d;
      vref_q <= vref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  dacpd_wake_timer #(
    .WAKE_CYC (WAKE_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_evt),
    .abort (abort),
    .busy  (busy)
  );

  dacpd_load_dec u_dec (
    .mode     (pd_q),
    .amp_en   (amp_en),
    .load_sel (load_sel)
  );

  assign out_valid = (pd_q == PD_ON) && !busy;

endmodule

// File: rtl/dacpd_ctrl.sv
module dacpd_ctrl
  import dacpd_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int CODE_W  = 12,
  parameter int CLK_HZ  = 250_000_000,
  parameter int WAKE_NS = 4500
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [((N_CH>1)?$clog2(N_CH):1)-1:0] wr_ch,
  input  logic [1:0]               wr_pd,
  input  logic                     wr_vref,
  input  logic                     gc_wake_stb,
  input  logic                     gc_reset_stb,
  input  logic [2*N_CH-1:0]        shadow_pd,
  input  logic [N_CH-1:0]          shadow_vref,
  input  logic [CODE_W*N_CH-1:0]   shadow_code,
  output logic [N_CH-1:0]          amp_en,
  output logic [LOAD_W*N_CH-1:0]   load_sel,
  output logic [N_CH-1:0]          out_valid,
  output logic                     vref_int_en,
  output logic [CODE_W*N_CH-1:0]   dac_code
);

  localparam int     CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam longint WAKE_PROD = longint'(CLK_HZ) * longint'(WAKE_NS);
  localparam int     WAKE_RAW  = int'((WAKE_PROD + 64'd999_999_999) / 64'd1_000_000_000);
  localparam int     WAKE_CYC  = (WAKE_RAW < 1) ? 1 : WAKE_RAW;
  localparam int     CNT_W     = $clog2(WAKE_CYC + 1);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [N_CH-1:0] vref_vec;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic sel;
    assign sel = wr_stb && (wr_ch == CH_W'(i));

    dacpd_chan #(
      .CODE_W   (CODE_W),
      .WAKE_CYC (WAKE_CYC),
      .CNT_W    (CNT_W)
    ) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_sel    (sel),
      .wr_pd     (wr_pd),
      .wr_vref   (wr_vref),
      .wake      (gc_wake_stb),
      .greset    (gc_reset_stb),
      .sh_pd     (shadow_pd[2*i +: 2]),
      .sh_vref   (shadow_vref[i]),
      .sh_code   (shadow_code[CODE_W*i +: CODE_W]),
      .amp_en    (amp_en[i]),
      .load_sel  (load_sel[LOAD_W*i +: LOAD_W]),
      .out_valid (out_valid[i]),
      .vref_q    (vref_vec[i]),
      .code_q    (dac_code[CODE_W*i +: CODE_W])
    );
  end

  assign vref_int_en = |vref_vec;

endmodule

// File: rtl/dacpd_ctrl_chk.sv
module dacpd_ctrl_chk #(
  parameter int N_CH   = 4,
  parameter int CODE_W = 12,
  parameter int CH_W   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_stb,
  input logic [CH_W-1:0]        wr_ch,
  input logic [1:0]             wr_pd,
  input logic                   gc_wake_stb,
  input logic                   gc_reset_stb,
  input logic [N_CH-1:0]        shadow_vref,
  input logic [N_CH-1:0]        amp_en,
  input logic [3*N_CH-1:0]      load_sel,
  input logic [N_CH-1:0]        out_valid,
  input logic                   vref_int_en,
  input logic [CODE_W*N_CH-1:0] dac_code
);

  // R4
  ext_ref_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_reset_stb && (shadow_vref == '0)) |=> !vref_int_en);

  // R4
  int_ref_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_reset_stb && (shadow_vref != '0)) |=> vref_int_en);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gc_reset_stb |=> $stable(dac_code));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    // R3
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(load_sel[3*i +: 3]) == (amp_en[i] ? 0 : 1));

    // R9
    valid_needs_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] |-> amp_en[i]);

    // R9
    wake_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(amp_en[i]) |-> !out_valid[i]);

    // R5
    write_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (wr_ch == CH_W'(i)) && (wr_pd == 2'b00) && !gc_reset_stb) |=> amp_en[i]);

    // R6
    wake_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gc_wake_stb && !gc_reset_stb && !(wr_stb && (wr_ch == CH_W'(i)))) |=> amp_en[i]);
  end

endmodule

bind dacpd_ctrl dacpd_ctrl_chk #(
  .N_CH   (N_CH),
  .CODE_W (CODE_W),
  .CH_W   (CH_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_stb       (wr_stb),
  .wr_ch        (wr_ch),
  .wr_pd        (wr_pd),
  .gc_wake_stb  (gc_wake_stb),
  .gc_reset_stb (gc_reset_stb),
  .shadow_vref  (shadow_vref),
  .amp_en       (amp_en),
  .load_sel     (load_sel),
  .out_valid    (out_valid),
  .vref_int_en  (vref_int_en),
  .dac_code     (dac_code)
);

// File: tb/dacpd_ctrl_test.sv
module dacpd_ctrl_test;

  localparam int NC    = 4;
  localparam int CW    = 12;
  // ceil(250e6 * 40 / 1e9) = 10 cycles
  localparam int EXP_W = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb, wr_vref, gc_wake_stb, gc_reset_stb;
  logic [1:0]    wr_ch, wr_pd;
  logic [2*NC-1:0]  shadow_pd;
  logic [NC-1:0]    shadow_vref;
  logic [CW*NC-1:0] shadow_code;
  logic [NC-1:0]    amp_en, out_valid;
  logic [3*NC-1:0]  load_sel;
  logic             vref_int_en;
  logic [CW*NC-1:0] dac_code;

  int n_chk = 0;
  int n_bad = 0;
  int m_pd[NC];
  int m_vref[NC];
  int m_code[NC];

  always #2 clk = ~clk;

  dacpd_ctrl #(.N_CH(NC), .CODE_W(CW), .CLK_HZ(250_000_000), .WAKE_NS(40)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_ch(wr_ch), .wr_pd(wr_pd),
    .wr_vref(wr_vref), .gc_wake_stb(gc_wake_stb), .gc_reset_stb(gc_reset_stb),
    .shadow_pd(shadow_pd), .shadow_vref(shadow_vref), .shadow_code(shadow_code),
    .amp_en(amp_en), .load_sel(load_sel), .out_valid(out_valid),
    .vref_int_en(vref_int_en), .dac_code(dac_code));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit with_valid);
    int any_int = 0;
    for (int c = 0; c < NC; c++) begin
      int exp_load = (m_pd[c] == 0) ? 0 : (1 << (m_pd[c] - 1));
      chk(amp_en[c] == (m_pd[c] == 0), req, $sformatf("amp_en[%0d]", c),
          int'(amp_en[c]), int'(m_pd[c] == 0));
      chk(int'(load_sel[3*c +: 3]) == exp_load, req, $sformatf("load_sel[%0d]", c),
          int'(load_sel[3*c +: 3]), exp_load);
      chk(int'(dac_code[CW*c +: CW]) == m_code[c], req, $sformatf("dac_code[%0d]", c),
          int'(dac_code[CW*c +: CW]), m_code[c]);
      if (with_valid)
        chk(out_valid[c] == (m_pd[c] == 0), req, $sformatf("out_valid[%0d]", c),
            int'(out_valid[c]), int'(m_pd[c] == 0));
      if (m_vref[c] != 0) any_int = 1;
    end
    chk(int'(vref_int_en) == any_int, req, "vref_int_en", int'(vref_int_en), any_int);
  endtask

  task automatic do_write(input int ch, input int pd, input int vr);
    @(negedge clk);
    wr_stb = 1'b1; wr_ch = 2'(ch); wr_pd = 2'(pd); wr_vref = vr[0];
    @(negedge clk);
    wr_stb = 1'b0;
    m_pd[ch] = pd; m_vref[ch] = vr;
  endtask

  task automatic do_wake();
    @(negedge clk);
    gc_wake_stb = 1'b1;
    @(negedge clk);
    gc_wake_stb = 1'b0;
    for (int c = 0; c < NC; c++) m_pd[c] = 0;
  endtask

  task automatic do_greset(input logic [2*NC-1:0] p, input logic [NC-1:0] v,
                           input logic [CW*NC-1:0] k);
    @(negedge clk);
    shadow_pd = p; shadow_vref = v; shadow_code = k; gc_reset_stb = 1'b1;
    @(negedge clk);
    gc_reset_stb = 1'b0;
    for (int c = 0; c < NC; c++) begin
      m_pd[c] = int'(p[2*c +: 2]); m_vref[c] = int'(v[c]); m_code[c] = int'(k[CW*c +: CW]);
    end
  endtask

  task automatic settle();
    repeat (EXP_W + 2) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_ch = '0; wr_pd = '0; wr_vref = 1'b0;
    gc_wake_stb = 1'b0; gc_reset_stb = 1'b0;
    shadow_pd = '0; shadow_vref = '0; shadow_code = '0;
    for (int c = 0; c < NC; c++) begin m_pd[c] = 0; m_vref[c] = 1; m_code[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check_all("R12", 1'b1);

    // R7 load codes so later mode changes can be seen not to touch them (R8)
    do_greset(8'h00, 4'hF, {12'hC03, 12'h802, 12'h401, 12'h0A5});
    settle();
    check_all("R7", 1'b1);

    // R1 R2 R3 R5 R8: sweep every channel through every mode and reference
    for (int ch = 0; ch < NC; ch++)
      for (int pd = 0; pd < 4; pd++)
        for (int vr = 0; vr < 2; vr++) begin
          do_write(ch, pd, vr);
          settle();
          check_all("R1 R2 R3 R5 R8", 1'b1);
        end

    // R4: every reference pattern, mixed modes
    for (int pat = 0; pat < 16; pat++) begin
      for (int ch = 0; ch < NC; ch++) do_write(ch, (pat + ch) % 4, (pat >> ch) & 1);
      @(negedge clk);
      chk(int'(vref_int_en) == int'(pat != 0), "R4", "vref_int_en",
          int'(vref_int_en), int'(pat != 0));
    end
    // R4: only a powered-down channel selects internal
    for (int ch = 0; ch < NC; ch++) do_write(ch, 0, 0);
    do_write(3, 2, 1);
    check_all("R4", 1'b0);

    // R6 wake clears all, keeps references and codes
    do_write(0, 1, 1); do_write(1, 2, 0); do_write(2, 3, 1); do_write(3, 1, 0);
    settle();
    do_wake();
    check_all("R6 R8", 1'b0);
    settle();
    check_all("R6", 1'b1);

    // R9 delay length
    do_write(2, 1, 1);
    settle();
    do_write(2, 0, 1);
    chk(out_valid[2] == 1'b0, "R9", "out_valid[2] first cycle", int'(out_valid[2]), 0);
    repeat (EXP_W - 1) @(negedge clk);
    chk(out_valid[2] == 1'b0, "R9", "out_valid[2] at WAKE_CYC", int'(out_valid[2]), 0);
    chk(out_valid[0] == 1'b1, "R1", "out_valid[0] untouched", int'(out_valid[0]), 1);
    @(negedge clk);
    chk(out_valid[2] == 1'b1, "R9", "out_valid[2] after WAKE_CYC", int'(out_valid[2]), 1);

    // R10 restart while counting
    do_write(1, 3, 1);
    settle();
    do_write(1, 0, 1);
    repeat (4) @(negedge clk);
    do_write(1, 0, 1);
    repeat (EXP_W - 1) @(negedge clk);
    chk(out_valid[1] == 1'b0, "R10", "out_valid[1] restarted", int'(out_valid[1]), 0);
    @(negedge clk);
    chk(out_valid[1] == 1'b1, "R10", "out_valid[1] after restart", int'(out_valid[1]), 1);

    // R11 write beats wake for its channel only
    do_write(0, 1, 1); do_write(1, 3, 1); do_write(2, 3, 0); do_write(3, 1, 0);
    settle();
    @(negedge clk);
    gc_wake_stb = 1'b1; wr_stb = 1'b1; wr_ch = 2'd1; wr_pd = 2'd2; wr_vref = 1'b0;
    @(negedge clk);
    gc_wake_stb = 1'b0; wr_stb = 1'b0;
    m_pd[0] = 0; m_pd[2] = 0; m_pd[3] = 0; m_pd[1] = 2; m_vref[1] = 0;
    settle();
    check_all("R11", 1'b1);

    // R11 reset beats write
    @(negedge clk);
    shadow_pd = 8'b01_00_10_11; shadow_vref = 4'b0110;
    shadow_code = {12'h111, 12'h222, 12'h333, 12'h444};
    gc_reset_stb = 1'b1; wr_stb = 1'b1; wr_ch = 2'd2; wr_pd = 2'd0; wr_vref = 1'b1;
    @(negedge clk);
    gc_reset_stb = 1'b0; wr_stb = 1'b0;
    m_pd[0] = 3; m_pd[1] = 2; m_pd[2] = 0; m_pd[3] = 1;
    m_vref[0] = 0; m_vref[1] = 1; m_vref[2] = 1; m_vref[3] = 0;
    m_code[0] = 'h444; m_code[1] = 'h333; m_code[2] = 'h222; m_code[3] = 'h111;
    settle();
    check_all("R11 R7", 1'b1);

    // R7 reset with all external references
    do_greset(8'b00_11_01_00, 4'b0000, {12'hFFF, 12'h000, 12'h5A5, 12'h123});
    settle();
    check_all("R7 R4", 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule